// File: doc/BRIEF.md
# Cascaded Second-Order IIR Filter Engine

This block filters a stream of converter samples with an infinite-impulse-response filter made of one, two or three second-order sections in direct form II. That gives 2, 4 or 6 poles. Each input strobe delivers one unsigned offset-binary sample. The engine flips the sample's top bit to turn it into a signed Q1.15 fraction. The sample then runs through the active sections in order, and the output of each section is the input of the next. A one-cycle done strobe marks the signed Q1.15 result.

A single shared signed multiplier and a wide accumulator do all the work. A small sequencer drives them and spends eight clock cycles on each active section. Coefficients live in a small write-only register bank. Each section has an input gain, two feedback terms, three feed-forward terms and a shift count, so coefficients larger than one can be realised. Each section also keeps two delay words. A synchronous clear zeroes the delay words and aborts any sample in flight. Sums that do not fit in 16 bits saturate instead of wrapping.

Top module: `iir_cascade_engine`

## Requirements
- R1: An accepted sample is made signed by inverting its most significant bit: sample 8000h enters the first section as 0, C000h as +0.5 (4000h), FFFFh as 7FFFh and 0000h as 8000h.
- R2: A product sum `acc` is scaled by the section shift count `s` (0..7) as floor(acc / 2^(15-s)). With s = 0 this equals shifting each 2.30 product left by one bit and keeping the upper word, so 0.5 × 0.5 gives 0.25 (2000h).
- R3: In each section the new state is M0 = scale(X·GAIN + M1·A1 + M2·A2), and only after that the output is Y = scale(M0·B0 + M1·B1 + M2·B2). All terms are added, and the signs are carried in the coefficients.
- R4: A scaled value above 7FFFh becomes 7FFFh, and one below 8000h (as a signed value) becomes 8000h.
- R5: After a section forms its output, M2 takes the old M1 and M1 takes the new M0, so a state word reaches M2 two samples after it was computed.
- R6: `num_sections` selects 1, 2 or 3 sections, and the value 0 acts as 1. Section k feeds section k+1, and the result is the output of the last active section.
- R7: `result_valid` is high for exactly one cycle, 8·N rising edges after the edge that accepted the sample, where N is the effective section count. `result` changes only in that cycle.
- R8: A sample strobe that arrives while `busy` is high is ignored: the result in flight and the filter state are unchanged. It sets `overrun`, which stays set until a clear.
- R9: While `clear` is high at an edge, every delay word and `overrun` become zero and the engine returns to idle.
- R10: Coefficient writes take effect only while idle, and a write while `busy` is dropped. `cfg_addr[4:3]` selects the section (0..2). `cfg_addr[2:0]` selects the field: 0 gain, 1 A1, 2 A2, 3 B0, 4 B1, 5 B2, 6 shift count (data bits 2:0). Field 7 and section 3 are ignored.
- R11: After reset `busy`, `overrun`, `result_valid` and `result` are 0, and every delay word and coefficient is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of delay words and overrun; aborts a sample |
| num_sections | input | 2 | Active section count (0 treated as 1) |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 5 | Section index [4:3], field code [2:0] |
| cfg_wdata | input | 16 | Coefficient write data |
| sample_valid | input | 1 | New sample strobe |
| sample_in | input | 16 | Offset-binary converter sample |
| busy | output | 1 | Engine is processing a sample |
| overrun | output | 1 | Sticky flag: a sample arrived while busy |
| result_valid | output | 1 | One-cycle done strobe |
| result | output | 16 | Signed Q1.15 filter output |

## Verification
The bench compares every output against a bit-exact integer model of the recurrence. It uses feedback strong enough that a wrong delay-line order or a missing state update shows up within a few samples, and a design that updated M1 before forming Y, or swapped M1 and M2, would give wrong values there. Hand-computed corner values catch a missing sign flip, a product scaled by the wrong power of two, and sums that wrap instead of clamping to 7FFFh or 8000h. Further cases start a second sample or a coefficient write while the engine is busy. A design that accepted either would corrupt the result in flight or a later one, and one that let the overrun flag clear itself would be caught by the next normal sample. A clear after heavy feedback, and section counts 0, 1, 2 and 3 with their latencies, complete the set.

// File: rtl/iir_cascade_pkg.sv
package iir_cascade_pkg;

   // clock cycles spent on one second-order section
   localparam int STEPS_PER_SECTION = 8;

   // coefficient field codes, decoded from the low address bits
   typedef enum logic [2:0] {
      FLD_GAIN  = 3'd0,
      FLD_A1    = 3'd1,
      FLD_A2    = 3'd2,
      FLD_B0    = 3'd3,
      FLD_B1    = 3'd4,
      FLD_B2    = 3'd5,
      FLD_SHIFT = 3'd6,
      FLD_NONE  = 3'd7
   } coef_field_e;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_RUN  = 1'b1
   } eng_state_e;

   // sequencing of one section: three feedback products, state update,
   // three feed-forward products, output and delay-line shift
   typedef enum logic [2:0] {
      ST_XG      = 3'd0,
      ST_M1A1    = 3'd1,
      ST_M2A2    = 3'd2,
      ST_LOAD_M0 = 3'd3,
      ST_M0B0    = 3'd4,
      ST_M1B1    = 3'd5,
      ST_M2B2    = 3'd6,
      ST_EMIT    = 3'd7
   } step_e;

endpackage

// File: rtl/iir_coef_bank.sv
module iir_coef_bank
   import iir_cascade_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int MAX_SECT = 3,
   parameter int SHIFT_W  = 3,
   parameter int SIDX_W   = 2,
   parameter int ADDR_W   = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     lock,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [SIDX_W-1:0]        rd_sect,
   output logic signed [DATA_W-1:0] gain,
   output logic signed [DATA_W-1:0] a1,
   output logic signed [DATA_W-1:0] a2,
   output logic signed [DATA_W-1:0] b0,
   output logic signed [DATA_W-1:0] b1,
   output logic signed [DATA_W-1:0] b2,
   output logic [SHIFT_W-1:0]       shift
);

   localparam int WORDS_W = MAX_SECT * DATA_W;
   localparam int SHFT_TW = MAX_SECT * SHIFT_W;

   logic [WORDS_W-1:0] gain_q, a1_q, a2_q, b0_q, b1_q, b2_q;
   logic [SHFT_TW-1:0] shift_q;

   logic [SIDX_W-1:0] wr_sect;
   coef_field_e       wr_field;

   assign wr_sect  = wr_addr[ADDR_W-1 -: SIDX_W];
   assign wr_field = coef_field_e'(wr_addr[2:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_q  <= '0;
         a1_q    <= '0;
         a2_q    <= '0;
         b0_q    <= '0;
         b1_q    <= '0;
         b2_q    <= '0;
         shift_q <= '0;
      end else if (wr_en && !lock) begin
         for (int s = 0; s < MAX_SECT; s++) begin
            if (wr_sect == SIDX_W'(s)) begin
               case (wr_field)
                  FLD_GAIN:  gain_q[s*DATA_W +: DATA_W]    <= wr_data;
                  FLD_A1:    a1_q[s*DATA_W +: DATA_W]      <= wr_data;
                  FLD_A2:    a2_q[s*DATA_W +: DATA_W]      <= wr_data;
                  FLD_B0:    b0_q[s*DATA_W +: DATA_W]      <= wr_data;
                  FLD_B1:    b1_q[s*DATA_W +: DATA_W]      <= wr_data;
                  FLD_B2:    b2_q[s*DATA_W +: DATA_W]      <= wr_data;
                  FLD_SHIFT: shift_q[s*SHIFT_W +: SHIFT_W] <= wr_data[SHIFT_W-1:0];
                  default: ;
               endcase
            end
         end
      end
   end

   assign gain  = gain_q[rd_sect*DATA_W +: DATA_W];
   assign a1    = a1_q[rd_sect*DATA_W +: DATA_W];
   assign a2    = a2_q[rd_sect*DATA_W +: DATA_W];
   assign b0    = b0_q[rd_sect*DATA_W +: DATA_W];
   assign b1    = b1_q[rd_sect*DATA_W +: DATA_W];
   assign b2    = b2_q[rd_sect*DATA_W +: DATA_W];
   assign shift = shift_q[rd_sect*SHIFT_W +: SHIFT_W];

endmodule

// File: rtl/iir_mac_unit.sv
module iir_mac_unit #(
   parameter int DATA_W   = 16,
   parameter int ACC_W    = 34,
   parameter int SHIFT_W  = 3,
   parameter bit SATURATE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en,
   input  logic                     restart,
   input  logic signed [DATA_W-1:0] op_a,
   input  logic signed [DATA_W-1:0] op_b,
   input  logic [SHIFT_W-1:0]       shift,
   output logic signed [DATA_W-1:0] norm
);

   localparam int PROD_W = 2 * DATA_W;
   localparam int RSH_W  = $clog2(DATA_W);
   localparam logic signed [ACC_W-1:0] POS_LIM =
      {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

   logic signed [PROD_W-1:0] product;
   logic signed [ACC_W-1:0]  prod_ext;
   logic signed [ACC_W-1:0]  acc_q;
   logic signed [ACC_W-1:0]  scaled;
   logic [RSH_W-1:0]         rsh;

   assign product  = op_a * op_b;
   assign prod_ext = {{(ACC_W-PROD_W){product[PROD_W-1]}}, product};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (en) begin
         acc_q <= (restart ? '0 : acc_q) + prod_ext;
      end
   end

   // a shift count s realises a gain of 2^(s+1) on the 2.30 sum before the
   // upper word is taken, i.e. an arithmetic right shift by DATA_W-1-s
   assign rsh    = RSH_W'(DATA_W - 1) - RSH_W'(shift);
   assign scaled = acc_q >>> rsh;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (scaled > POS_LIM)      norm = POS_LIM[DATA_W-1:0];
            else if (scaled < NEG_LIM) norm = NEG_LIM[DATA_W-1:0];
            else                       norm = scaled[DATA_W-1:0];
         end
      end else begin : g_wrap
         assign norm = scaled[DATA_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/iir_delay_store.sv
module iir_delay_store #(
   parameter int DATA_W   = 16,
   parameter int MAX_SECT = 3,
   parameter int SIDX_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     push,
   input  logic [SIDX_W-1:0]        sect,
   input  logic signed [DATA_W-1:0] m0_in,
   output logic signed [DATA_W-1:0] m1_out,
   output logic signed [DATA_W-1:0] m2_out
);

   localparam int WORDS_W = MAX_SECT * DATA_W;

   logic [WORDS_W-1:0] m1_flat;
   logic [WORDS_W-1:0] m2_flat;

   generate
      for (genvar s = 0; s < MAX_SECT; s++) begin : g_sect
         logic [DATA_W-1:0] m1_q;
         logic [DATA_W-1:0] m2_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               m1_q <= '0;
               m2_q <= '0;
            end else if (clear) begin
               m1_q <= '0;
               m2_q <= '0;
            end else if (push && (sect == SIDX_W'(s))) begin
               m2_q <= m1_q;
               m1_q <= m0_in;
            end
         end

         assign m1_flat[s*DATA_W +: DATA_W] = m1_q;
         assign m2_flat[s*DATA_W +: DATA_W] = m2_q;
      end
   endgenerate

   assign m1_out = m1_flat[sect*DATA_W +: DATA_W];
   assign m2_out = m2_flat[sect*DATA_W +: DATA_W];

endmodule

// File: rtl/iir_cascade_engine.sv
module iir_cascade_engine
   import iir_cascade_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int MAX_SECT = 3,
   parameter int SHIFT_W  = 3,
   parameter int ACC_W    = 2 * DATA_W + 2,
   parameter bit SATURATE = 1'b1,
   localparam int SIDX_W  = $clog2(MAX_SECT),
   localparam int SECT_W  = $clog2(MAX_SECT + 1),
   localparam int ADDR_W  = SIDX_W + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [SECT_W-1:0] num_sections,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              sample_valid,
   input  logic [DATA_W-1:0] sample_in,
   output logic              busy,
   output logic              overrun,
   output logic              result_valid,
   output logic [DATA_W-1:0] result
);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("iir_cascade_engine: DATA_W must be at least 8");
      end
      if (MAX_SECT < 2) begin : g_bad_sect
         $error("iir_cascade_engine: MAX_SECT must be at least 2");
      end
      if (ACC_W < 2 * DATA_W + 2) begin : g_bad_acc
         $error("iir_cascade_engine: ACC_W too narrow for three products");
      end
      if ((2 ** SHIFT_W) - 1 > DATA_W - 2) begin : g_bad_shift
         $error("iir_cascade_engine: SHIFT_W allows shifts past the word");
      end
   endgenerate

   eng_state_e        state_q;
   step_e             step_q;
   logic [SIDX_W-1:0] sect_q;
   logic [SIDX_W-1:0] last_q;
   logic signed [DATA_W-1:0] x_q;
   logic signed [DATA_W-1:0] m0_q;

   logic signed [DATA_W-1:0] c_gain, c_a1, c_a2, c_b0, c_b1, c_b2;
   logic [SHIFT_W-1:0]       c_shift;
   logic signed [DATA_W-1:0] m1_w, m2_w;
   logic signed [DATA_W-1:0] mac_a, mac_b, mac_norm;
   logic                     mac_en, mac_restart;
   logic                     push;
   logic [SECT_W-1:0]        n_eff;
   logic                     running;

   assign running = (state_q == ENG_RUN);
   assign busy    = running;

   always_comb begin
      if (num_sections == '0)
         n_eff = SECT_W'(1);
      else if (num_sections > SECT_W'(MAX_SECT))
         n_eff = SECT_W'(MAX_SECT);
      else
         n_eff = num_sections;
   end

   iir_coef_bank #(
      .DATA_W  (DATA_W),
      .MAX_SECT(MAX_SECT),
      .SHIFT_W (SHIFT_W),
      .SIDX_W  (SIDX_W),
      .ADDR_W  (ADDR_W)
   ) i_coef_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .lock   (running),
      .wr_addr(cfg_addr),
      .wr_data(cfg_wdata),
      .rd_sect(sect_q),
      .gain   (c_gain),
      .a1     (c_a1),
      .a2     (c_a2),
      .b0     (c_b0),
      .b1     (c_b1),
      .b2     (c_b2),
      .shift  (c_shift)
   );

   iir_delay_store #(
      .DATA_W  (DATA_W),
      .MAX_SECT(MAX_SECT),
      .SIDX_W  (SIDX_W)
   ) i_delay_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .push  (push),
      .sect  (sect_q),
      .m0_in (m0_q),
      .m1_out(m1_w),
      .m2_out(m2_w)
   );

   iir_mac_unit #(
      .DATA_W  (DATA_W),
      .ACC_W   (ACC_W),
      .SHIFT_W (SHIFT_W),
      .SATURATE(SATURATE)
   ) i_mac_unit (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (mac_en),
      .restart(mac_restart),
      .op_a   (mac_a),
      .op_b   (mac_b),
      .shift  (c_shift),
      .norm   (mac_norm)
   );

   // operand selection for the shared multiplier
   always_comb begin
      mac_a       = x_q;
      mac_b       = c_gain;
      mac_restart = 1'b0;
      mac_en      = running;
      case (step_q)
         ST_XG:      begin mac_a = x_q;  mac_b = c_gain; mac_restart = 1'b1; end
         ST_M1A1:    begin mac_a = m1_w; mac_b = c_a1; end
         ST_M2A2:    begin mac_a = m2_w; mac_b = c_a2; end
         ST_M0B0:    begin mac_a = m0_q; mac_b = c_b0; mac_restart = 1'b1; end
         ST_M1B1:    begin mac_a = m1_w; mac_b = c_b1; end
         ST_M2B2:    begin mac_a = m2_w; mac_b = c_b2; end
         default:    mac_en = 1'b0;
      endcase
   end

   assign push = running && (step_q == ST_EMIT) && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ENG_IDLE;
         step_q       <= ST_XG;
         sect_q       <= '0;
         last_q       <= '0;
         x_q          <= '0;
         m0_q         <= '0;
         overrun      <= 1'b0;
         result_valid <= 1'b0;
         result       <= '0;
      end else begin
         result_valid <= 1'b0;
         if (clear) begin
            state_q <= ENG_IDLE;
            step_q  <= ST_XG;
            sect_q  <= '0;
            overrun <= 1'b0;
         end else begin
            if (sample_valid && running)
               overrun <= 1'b1;
            case (state_q)
               ENG_IDLE: begin
                  if (sample_valid) begin
                     x_q     <= {~sample_in[DATA_W-1], sample_in[DATA_W-2:0]};
                     last_q  <= SIDX_W'(n_eff - SECT_W'(1));
                     sect_q  <= '0;
                     step_q  <= ST_XG;
                     state_q <= ENG_RUN;
                  end
               end
               default: begin
                  case (step_q)
                     ST_LOAD_M0: begin
                        m0_q   <= mac_norm;
                        step_q <= ST_M0B0;
                     end
                     ST_EMIT: begin
                        x_q    <= mac_norm;
                        step_q <= ST_XG;
                        if (sect_q == last_q) begin
                           result       <= mac_norm;
                           result_valid <= 1'b1;
                           state_q      <= ENG_IDLE;
                           sect_q       <= '0;
                        end else begin
                           sect_q <= sect_q + SIDX_W'(1);
                        end
                     end
                     default: step_q <= step_e'(step_q + 3'd1);
                  endcase
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/iir_cascade_checker.sv
module iir_cascade_checker
   import iir_cascade_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int MAX_SECT = 3,
   parameter int SECT_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear,
   input logic [SECT_W-1:0] num_sections,
   input logic              sample_valid,
   input logic              busy,
   input logic              overrun,
   input logic              result_valid,
   input logic [DATA_W-1:0] result
);

   logic [15:0] lat_cnt;
   logic [15:0] lat_exp;
   int          n_req;

   always_comb begin
      if (num_sections == '0)                       n_req = 1;
      else if (int'(num_sections) > MAX_SECT)       n_req = MAX_SECT;
      else                                          n_req = int'(num_sections);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt <= '0;
         lat_exp <= '0;
      end else if (clear) begin
         lat_cnt <= '0;
      end else if (sample_valid && !busy) begin
         lat_cnt <= '0;
         lat_exp <= 16'(STEPS_PER_SECTION * n_req);
      end else if (busy) begin
         lat_cnt <= lat_cnt + 16'd1;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid); // R7

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (lat_cnt == lat_exp)); // R7

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> result_valid); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !busy); // R7

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sample_valid && !clear) |=> overrun); // R8

   AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clear) |=> overrun); // R8

   AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (!busy && !overrun)); // R9

endmodule

bind iir_cascade_engine iir_cascade_checker #(
   .DATA_W  (DATA_W),
   .MAX_SECT(MAX_SECT),
   .SECT_W  (SECT_W)
) i_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .clear       (clear),
   .num_sections(num_sections),
   .sample_valid(sample_valid),
   .busy        (busy),
   .overrun     (overrun),
   .result_valid(result_valid),
   .result      (result)
);

// File: tb/test_iir_cascade_engine.sv
`timescale 1ns/1ps
module test_iir_cascade_engine;

   localparam real CLK_PERIOD = 10.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear = 1'b0;
   logic [1:0]  num_sections = 2'd1;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        sample_valid = 1'b0;
   logic [15:0] sample_in = '0;
   logic        busy, overrun, result_valid;
   logic [15:0] result;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // reference model state
   longint m_gain[3], m_a1[3], m_a2[3], m_b0[3], m_b1[3], m_b2[3];
   int     m_sh[3];
   longint m_m1[3], m_m2[3];
   int unsigned lcg = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   iir_cascade_engine i_iir_cascade_engine (
      .clk(clk), .rst_n(rst_n), .clear(clear), .num_sections(num_sections),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sample_valid(sample_valid), .sample_in(sample_in),
      .busy(busy), .overrun(overrun), .result_valid(result_valid), .result(result)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic longint scale_sat(longint acc, int sh);
      longint v;
      v = acc >>> (15 - sh);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic logic [15:0] model_step(logic [15:0] s);
      longint x, acc, m0, y;
      int n;
      n = (num_sections == 2'd0) ? 1 : int'(num_sections);
      x = longint'($signed(s ^ 16'h8000));
      y = 0;
      for (int i = 0; i < n; i++) begin
         acc = x * m_gain[i] + m_m1[i] * m_a1[i] + m_m2[i] * m_a2[i];
         m0  = scale_sat(acc, m_sh[i]);
         acc = m0 * m_b0[i] + m_m1[i] * m_b1[i] + m_m2[i] * m_b2[i];
         y   = scale_sat(acc, m_sh[i]);
         m_m2[i] = m_m1[i];
         m_m1[i] = m0;
         x = y;
      end
      return y[15:0];
   endfunction

   function automatic void model_clear();
      for (int i = 0; i < 3; i++) begin
         m_m1[i] = 0;
         m_m2[i] = 0;
      end
   endfunction

   task automatic cfg_write(input int sect, input int fld, input logic [15:0] d,
                            input bit track);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = {sect[1:0], fld[2:0]};
      cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (track && sect < 3) begin
         case (fld)
            0: m_gain[sect] = longint'($signed(d));
            1: m_a1[sect]   = longint'($signed(d));
            2: m_a2[sect]   = longint'($signed(d));
            3: m_b0[sect]   = longint'($signed(d));
            4: m_b1[sect]   = longint'($signed(d));
            5: m_b2[sect]   = longint'($signed(d));
            6: m_sh[sect]   = int'(d[2:0]);
            default: ;
         endcase
      end
   endtask

   task automatic set_section(input int s, input logic [15:0] g, a1, a2,
                              b0, b1, b2, input int sh);
      cfg_write(s, 0, g, 1'b1);
      cfg_write(s, 1, a1, 1'b1);
      cfg_write(s, 2, a2, 1'b1);
      cfg_write(s, 3, b0, 1'b1);
      cfg_write(s, 4, b1, 1'b1);
      cfg_write(s, 5, b2, 1'b1);
      cfg_write(s, 6, 16'(sh), 1'b1);
   endtask

   task automatic do_clear();
      @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
      model_clear();
   endtask

   // intrude: 0 none, 1 second sample while busy, 2 coefficient write while busy
   task automatic run_sample(input logic [15:0] s, input string req,
                             input int intrude, output logic [15:0] got);
      logic [15:0] exp;
      int n, lat;
      n   = (num_sections == 2'd0) ? 1 : int'(num_sections);
      exp = model_step(s);
      @(negedge clk);
      sample_valid = 1'b1;
      sample_in    = s;
      @(negedge clk);
      sample_valid = 1'b0;
      lat = 0;
      if (intrude == 1) begin
         @(negedge clk); lat++;
         sample_valid = 1'b1;
         sample_in    = ~s;
         @(negedge clk); lat++;
         sample_valid = 1'b0;
      end else if (intrude == 2) begin
         @(negedge clk); lat++;
         cfg_we    = 1'b1;
         cfg_addr  = 5'b00_000;
         cfg_wdata = 16'h1000;
         @(negedge clk); lat++;
         cfg_we = 1'b0;
      end
      while (!result_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      got = result;
      check(result_valid == 1'b1, req, "done strobe", longint'(result_valid), 1);
      check(result == exp, req, "result", longint'(result), longint'(exp));
      check(lat == 8 * n, "R7", "latency", lat, 8 * n);
      @(negedge clk);
      check(result_valid == 1'b0, "R7", "strobe width", longint'(result_valid), 0);
   endtask

   task automatic run_stream(input int count, input string req);
      logic [15:0] got;
      for (int k = 0; k < count; k++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         run_sample(lcg[23:8], req, 0, got);
      end
   endtask

   task automatic load_rich();
      set_section(0, 16'h4000, 16'h5000, 16'hD000, 16'h2000, 16'h4000, 16'h2000, 1);
      set_section(1, 16'h7000, 16'h2000, 16'hE800, 16'h3000, 16'hA000, 16'h3000, 2);
      set_section(2, 16'h6000, 16'hC000, 16'h1000, 16'h4000, 16'h0800, 16'hF000, 0);
   endtask

   task automatic test_reset();
      check(busy == 1'b0, "R11", "busy", longint'(busy), 0);
      check(overrun == 1'b0, "R11", "overrun", longint'(overrun), 0);
      check(result_valid == 1'b0, "R11", "result_valid", longint'(result_valid), 0);
      check(result == 16'h0, "R11", "result", longint'(result), 0);
   endtask

   task automatic test_sign_and_scale();
      logic [15:0] got;
      num_sections = 2'd1;
      set_section(0, 16'h4000, 16'h0000, 16'h0000, 16'h4000, 16'h0000, 16'h0000, 0);
      run_sample(16'h8000, "R1", 0, got);
      check(got == 16'h0000, "R1", "mid-scale code", longint'(got), 0);
      run_sample(16'hC000, "R2", 0, got);
      check(got == 16'h1000, "R2", "0.5*0.5*0.5", longint'(got), 16'h1000);
      // shift count 1 doubles: M0 = 0.5, Y = 0.5*0.5*2 = 0.5
      cfg_write(0, 6, 16'h0001, 1'b1);
      run_sample(16'hC000, "R2", 0, got);
      check(got == 16'h4000, "R2", "shift one", longint'(got), 16'h4000);
   endtask

   task automatic test_saturation();
      logic [15:0] got;
      do_clear();
      num_sections = 2'd1;
      set_section(0, 16'h7FFF, 16'h0000, 16'h0000, 16'h7FFF, 16'h0000, 16'h0000, 7);
      run_sample(16'hFFFF, "R4", 0, got);
      check(got == 16'h7FFF, "R4", "positive clamp", longint'(got), 16'h7FFF);
      run_sample(16'h0000, "R4", 0, got);
      check(got == 16'h8000, "R4", "negative clamp", longint'(got), 16'h8000);
   endtask

   task automatic test_delay_order();
      logic [15:0] got;
      do_clear();
      num_sections = 2'd1;
      set_section(0, 16'h4000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h7FFF, 0);
      run_sample(16'hC000, "R5", 0, got);
      check(got == 16'h0000, "R5", "impulse step 0", longint'(got), 0);
      run_sample(16'h8000, "R5", 0, got);
      check(got == 16'h0000, "R5", "impulse step 1", longint'(got), 0);
      run_sample(16'h8000, "R5", 0, got);
      check(got == 16'h1FFF, "R5", "impulse step 2", longint'(got), 16'h1FFF);
      run_sample(16'h8000, "R5", 0, got);
      check(got == 16'h0000, "R5", "impulse step 3", longint'(got), 0);
   endtask

   task automatic test_recurrence();
      do_clear();
      load_rich();
      num_sections = 2'd1;
      run_stream(30, "R3");
   endtask

   task automatic test_cascade();
      do_clear();
      num_sections = 2'd2;
      run_stream(20, "R6");
      do_clear();
      num_sections = 2'd3;
      run_stream(20, "R6");
      do_clear();
      num_sections = 2'd0;
      run_stream(6, "R6");
   endtask

   task automatic test_overrun();
      logic [15:0] got;
      do_clear();
      num_sections = 2'd2;
      run_sample(16'hA5A5, "R8", 1, got);
      check(overrun == 1'b1, "R8", "flag set", longint'(overrun), 1);
      run_sample(16'h3C3C, "R8", 0, got);
      check(overrun == 1'b1, "R8", "flag sticky", longint'(overrun), 1);
      do_clear();
      check(overrun == 1'b0, "R9", "flag cleared", longint'(overrun), 0);
   endtask

   task automatic test_clear();
      do_clear();
      num_sections = 2'd3;
      run_stream(10, "R9");
      do_clear();
      check(busy == 1'b0, "R9", "idle after clear", longint'(busy), 0);
      run_stream(3, "R9");
   endtask

   task automatic test_cfg_lock();
      logic [15:0] got;
      do_clear();
      num_sections = 2'd1;
      run_sample(16'hD000, "R10", 2, got);
      run_sample(16'h9000, "R10", 0, got);
      // field 7 and section 3 writes have no target
      cfg_write(0, 7, 16'h7FFF, 1'b0);
      cfg_write(3, 0, 16'h7FFF, 1'b0);
      run_sample(16'hE000, "R10", 0, got);
   endtask

   initial begin
      for (int i = 0; i < 3; i++) begin
         m_gain[i] = 0; m_a1[i] = 0; m_a2[i] = 0;
         m_b0[i] = 0; m_b1[i] = 0; m_b2[i] = 0; m_sh[i] = 0;
      end
      model_clear();
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_sign_and_scale();
      test_saturation();
      test_delay_order();
      test_recurrence();
      test_cascade();
      test_overrun();
      test_clear();
      test_cfg_lock();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all): actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule